// File: doc/BRIEF.md
# Sector-Aligning DMA Transfer Adapter

This block connects a DMA engine that works in bytes to a storage port that works only in whole 512-byte sectors. A request gives a byte offset, a byte length and a direction. The adapter turns it into one sector command per covered sector, in ascending order. On a read, the adapter streams every byte of each covered sector in from storage and passes on to the DMA side only the bytes inside the requested range. Bytes before the offset in the first sector and bytes after the end in the last sector are dropped.

On a write, a partly covered first or last sector must not lose its existing contents. The adapter reads those edge sectors into local sector buffers before any write command goes out. It then writes whole sectors. Bytes inside the range come from the DMA stream. Bytes outside it come from the buffers. When the start and the end fall in the same sector, that sector is read only once. A fully aligned write goes straight to storage with no read-back.

A busy/done handshake reports completion. A storage error ends the request at once, with an error flag beside the done pulse. Two transfer counters sit beside the request path. A remaining-bytes counter is reduced by each completed request's length and stops at zero. A byte index is advanced by the same amount. Both are loaded at the start of a transfer.

State machine states: IDLE (waits for a request), RB_CMD (issues a read-back command for an edge sector), RB_DATA (fills a sector buffer), SEC_CMD (issues the main command for the current sector), RD_DATA (forwards read data), WR_DATA (streams merged write data) and FINISH (one-cycle done). Transitions:
- IDLE goes to FINISH on a zero-length request, to RB_CMD on a write with a misaligned edge, and otherwise to SEC_CMD.
- RB_CMD always goes to RB_DATA.
- RB_DATA goes back to RB_CMD after the head sector when a separate tail sector is still needed, and otherwise to SEC_CMD.
- SEC_CMD goes to WR_DATA for a write and to RD_DATA for a read.
- RD_DATA and WR_DATA go to SEC_CMD after each sector except the last, and to FINISH after the last.
- Any active state goes to FINISH on a storage error.
- FINISH always goes to IDLE.

Top module: `sector_align_dma`

## Requirements
- R1: After reset, busy, done, done_err, sto_cmd_valid, sto_wr_valid, dma_out_valid and dma_in_ready are 0, and xfer_remain and xfer_index are 0.
- R2: A request is taken only while busy is 0. Once taken, busy stays 1 until the done cycle, and a req_valid during that time has no effect on commands or data.
- R3: On a read (req_write = 0), dma_out delivers exactly the bytes at addresses req_offset to req_offset+req_len-1, in address order, one per dma_out_valid cycle. Leading bytes of the first sector and trailing bytes of the last sector are dropped. No storage write command is issued.
- R4: The sector number on sto_cmd_sector is the byte address shifted right by 9. Main commands run from sector req_offset>>9 to (req_offset+req_len-1)>>9, one per sector, in ascending order. sto_cmd_write = 1 marks a write command and 0 a read command.
- R5: On a write whose offset is not a multiple of 512, the first sector is read back, and its bytes below the offset are written back unchanged.
- R6: On a write whose end (offset+length) is not a multiple of 512, the last sector is read back, and its bytes at and after the end are written back unchanged.
- R7: When the first and last sectors of a misaligned write are the same sector, that sector is read back exactly once.
- R8: A write that is aligned at both ends issues no read-back command.
- R9: All read-back commands of a write are issued before its first write command.
- R10: xfer_load sets xfer_remain to xfer_size and xfer_index to 0. Each request that completes without error lowers xfer_remain by its length (never below 0) and raises xfer_index by its length.
- R11: A storage error (sto_err = 1) while busy ends the request. The next cycle has done = 1 with done_err = 1, no further commands follow, and the transfer counters are left unchanged.
- R12: A zero-length request completes with done and issues no storage command.
- R13: done is a one-cycle pulse, and busy is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = write to storage, 0 = read from storage |
| req_offset | input | 32 | Byte offset of the request |
| req_len | input | 16 | Byte length of the request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request ended by a storage error, valid with done |
| xfer_load | input | 1 | Load the transfer counters |
| xfer_size | input | 24 | Total transfer size loaded into xfer_remain |
| xfer_remain | output | 24 | Remaining bytes of the transfer |
| xfer_index | output | 24 | Bytes completed so far |
| dma_in_valid | input | 1 | Write data byte available from DMA |
| dma_in_data | input | 8 | Write data byte |
| dma_in_ready | output | 1 | Adapter takes a write byte this cycle when valid |
| dma_out_valid | output | 1 | Read data byte to DMA |
| dma_out_data | output | 8 | Read data byte |
| sto_cmd_valid | output | 1 | One-cycle sector command |
| sto_cmd_write | output | 1 | 1 = sector write, 0 = sector read |
| sto_cmd_sector | output | 23 | Sector number |
| sto_rd_valid | input | 1 | Sector read byte from storage |
| sto_rd_data | input | 8 | Sector read byte |
| sto_wr_valid | output | 1 | Sector write byte to storage (always accepted) |
| sto_wr_data | output | 8 | Sector write byte |
| sto_err | input | 1 | Storage error |

## Verification
A byte counter or sector number that slips shows up at the DMA side within one sector's worth of bytes. The stream carries a wrong or shifted byte, or the wrong count of bytes, before done. A wrong read-back decision, or a buffer filled from the wrong sector, shows up as a corrupted edge byte in storage after the write, or as an extra or missing read command in the command log. A request flag that is not cleared between requests shows up on the next request as a stray done_err or a counter that does not move.

// File: rtl/sad_pkg.sv
package sad_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RB_CMD,
        ST_RB_DATA,
        ST_SEC_CMD,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_FINISH
    } sad_state_e;
endpackage

// File: rtl/sad_geom.sv
// Request geometry: sector span and edge alignment, purely combinational.
module sad_geom #(
    parameter int OFF_W     = 32,
    parameter int LEN_W     = 16,
    parameter int SECT_LOG2 = 9
) (
    input  logic [OFF_W-1:0]           off,
    input  logic [LEN_W-1:0]           len,
    input  logic                       is_write,
    output logic [OFF_W-1:0]           end_pos,
    output logic [OFF_W-SECT_LOG2-1:0] first_sec,
    output logic [OFF_W-SECT_LOG2-1:0] last_sec,
    output logic                       zero_len,
    output logic                       same_sec,
    output logic                       rb_head,
    output logic                       rb_tail
);
    localparam int SEC_W = OFF_W - SECT_LOG2;

    logic [SECT_LOG2-1:0] head_mis;
    logic [SECT_LOG2-1:0] tail_mis;

    always_comb begin
        end_pos   = off + OFF_W'(len);
        head_mis  = off[SECT_LOG2-1:0];
        tail_mis  = end_pos[SECT_LOG2-1:0];
        first_sec = off[OFF_W-1:SECT_LOG2];
        // an aligned end belongs to the sector before it
        last_sec  = end_pos[OFF_W-1:SECT_LOG2] - SEC_W'(tail_mis == '0);
        zero_len  = (len == '0);
        same_sec  = (first_sec == last_sec);
        rb_head   = is_write && !zero_len &&
                    ((head_mis != '0) || (same_sec && (tail_mis != '0)));
        rb_tail   = is_write && !zero_len && (tail_mis != '0) && !same_sec;
    end
endmodule

// File: rtl/sad_sect_buf.sv
// One sector of byte storage, synchronous write, combinational read.
module sad_sect_buf #(
    parameter int SECT_LOG2 = 9
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [SECT_LOG2-1:0] waddr,
    input  logic [7:0]           wdata,
    input  logic [SECT_LOG2-1:0] raddr,
    output logic [7:0]           rdata
);
    localparam int SECT_BYTES = 1 << SECT_LOG2;

    logic [7:0] mem [SECT_BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sad_xfer_count.sv
// Remaining-bytes and byte-index counters for a multi-request transfer.
module sad_xfer_count #(
    parameter int CNT_W = 24,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] size,
    input  logic             upd,
    input  logic [LEN_W-1:0] amount,
    output logic [CNT_W-1:0] remain,
    output logic [CNT_W-1:0] index
);
    logic [CNT_W-1:0] amt_ext;
    assign amt_ext = CNT_W'(amount);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            index  <= '0;
        end else if (load) begin
            remain <= size;
            index  <= '0;
        end else if (upd) begin
            remain <= (amt_ext > remain) ? '0 : remain - amt_ext;
            index  <= index + amt_ext;
        end
    end

    AST_REMAIN_NONINCREASE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (remain <= $past(remain)));  // R10
endmodule

// File: rtl/sector_align_dma.sv
module sector_align_dma
    import sad_pkg::*;
#(
    parameter int OFF_W     = 32,
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 24,
    parameter int SECT_LOG2 = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [OFF_W-1:0]           req_offset,
    input  logic [LEN_W-1:0]           req_len,
    output logic                       busy,
    output logic                       done,
    output logic                       done_err,
    input  logic                       xfer_load,
    input  logic [CNT_W-1:0]           xfer_size,
    output logic [CNT_W-1:0]           xfer_remain,
    output logic [CNT_W-1:0]           xfer_index,
    input  logic                       dma_in_valid,
    input  logic [7:0]                 dma_in_data,
    output logic                       dma_in_ready,
    output logic                       dma_out_valid,
    output logic [7:0]                 dma_out_data,
    output logic                       sto_cmd_valid,
    output logic                       sto_cmd_write,
    output logic [OFF_W-SECT_LOG2-1:0] sto_cmd_sector,
    input  logic                       sto_rd_valid,
    input  logic [7:0]                 sto_rd_data,
    output logic                       sto_wr_valid,
    output logic [7:0]                 sto_wr_data,
    input  logic                       sto_err
);
    localparam int SEC_W = OFF_W - SECT_LOG2;

    // ---------------- request geometry ----------------
    logic [OFF_W-1:0] g_end;
    logic [SEC_W-1:0] g_first, g_last;
    logic             g_zero, g_same, g_rb_head, g_rb_tail;

    sad_geom #(.OFF_W(OFF_W), .LEN_W(LEN_W), .SECT_LOG2(SECT_LOG2)) u_geom (
        .off      (req_offset),
        .len      (req_len),
        .is_write (req_write),
        .end_pos  (g_end),
        .first_sec(g_first),
        .last_sec (g_last),
        .zero_len (g_zero),
        .same_sec (g_same),
        .rb_head  (g_rb_head),
        .rb_tail  (g_rb_tail)
    );

    // ---------------- state and request registers ----------------
    sad_state_e state_q, state_d;

    logic [OFF_W-1:0]     off_q, end_q;
    logic [LEN_W-1:0]     len_q;
    logic [SEC_W-1:0]     first_q, last_q, cur_q;
    logic [SECT_LOG2-1:0] bcnt_q;
    logic                 wr_q, same_q, rb_tail_q, rb_sel_q, err_q;

    logic             accept, active, abort, byte_last;
    logic             in_range, before_off, wr_fire;
    logic [OFF_W-1:0] abs_pos;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign active     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign abort      = active && sto_err;
    assign byte_last  = &bcnt_q;
    assign abs_pos    = {cur_q, bcnt_q};
    assign before_off = (abs_pos < off_q);
    assign in_range   = !before_off && (abs_pos < end_q);
    assign wr_fire    = (state_q == ST_WR_DATA) && (!in_range || dma_in_valid);

    // ---------------- edge sector buffers: 0 = head, 1 = tail ----------------
    logic       buf_we [2];
    logic [7:0] buf_rd [2];

    for (genvar g = 0; g < 2; g++) begin : g_buf
        assign buf_we[g] = (state_q == ST_RB_DATA) && sto_rd_valid &&
                           (rb_sel_q == 1'(g));
        sad_sect_buf #(.SECT_LOG2(SECT_LOG2)) u_buf (
            .clk  (clk),
            .we   (buf_we[g]),
            .waddr(bcnt_q),
            .wdata(sto_rd_data),
            .raddr(bcnt_q),
            .rdata(buf_rd[g])
        );
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (g_zero)                     state_d = ST_FINISH;
                    else if (g_rb_head || g_rb_tail) state_d = ST_RB_CMD;
                    else                            state_d = ST_SEC_CMD;
                end
            end
            ST_RB_CMD: state_d = abort ? ST_FINISH : ST_RB_DATA;
            ST_RB_DATA: begin
                if (abort) state_d = ST_FINISH;
                else if (sto_rd_valid && byte_last)
                    state_d = (!rb_sel_q && rb_tail_q) ? ST_RB_CMD : ST_SEC_CMD;
            end
            ST_SEC_CMD: begin
                if (abort)     state_d = ST_FINISH;
                else if (wr_q) state_d = ST_WR_DATA;
                else           state_d = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (abort) state_d = ST_FINISH;
                else if (sto_rd_valid && byte_last)
                    state_d = (cur_q == last_q) ? ST_FINISH : ST_SEC_CMD;
            end
            ST_WR_DATA: begin
                if (abort) state_d = ST_FINISH;
                else if (wr_fire && byte_last)
                    state_d = (cur_q == last_q) ? ST_FINISH : ST_SEC_CMD;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q     <= '0;
            end_q     <= '0;
            len_q     <= '0;
            first_q   <= '0;
            last_q    <= '0;
            cur_q     <= '0;
            bcnt_q    <= '0;
            wr_q      <= 1'b0;
            same_q    <= 1'b0;
            rb_tail_q <= 1'b0;
            rb_sel_q  <= 1'b0;
            err_q     <= 1'b0;
        end else if (accept) begin
            off_q     <= req_offset;
            end_q     <= g_end;
            len_q     <= req_len;
            first_q   <= g_first;
            last_q    <= g_last;
            cur_q     <= g_first;
            bcnt_q    <= '0;
            wr_q      <= req_write;
            same_q    <= g_same;
            rb_tail_q <= g_rb_tail;
            rb_sel_q  <= !g_rb_head;
            err_q     <= 1'b0;
        end else begin
            if (abort) err_q <= 1'b1;
            if (!sto_err) begin
                case (state_q)
                    ST_RB_DATA: if (sto_rd_valid) begin
                        bcnt_q <= bcnt_q + SECT_LOG2'(1);
                        if (byte_last) rb_sel_q <= 1'b1;
                    end
                    ST_RD_DATA: if (sto_rd_valid) begin
                        bcnt_q <= bcnt_q + SECT_LOG2'(1);
                        if (byte_last) cur_q <= cur_q + SEC_W'(1);
                    end
                    ST_WR_DATA: if (wr_fire) begin
                        bcnt_q <= bcnt_q + SECT_LOG2'(1);
                        if (byte_last) cur_q <= cur_q + SEC_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy           = (state_q != ST_IDLE);
        done           = 1'b0;
        done_err       = 1'b0;
        sto_cmd_valid  = 1'b0;
        sto_cmd_write  = 1'b0;
        sto_cmd_sector = cur_q;
        dma_out_valid  = 1'b0;
        dma_out_data   = sto_rd_data;
        dma_in_ready   = 1'b0;
        sto_wr_valid   = 1'b0;
        sto_wr_data    = dma_in_data;
        unique case (state_q)
            ST_RB_CMD: begin
                sto_cmd_valid  = 1'b1;
                sto_cmd_sector = rb_sel_q ? last_q : first_q;
            end
            ST_SEC_CMD: begin
                sto_cmd_valid = 1'b1;
                sto_cmd_write = wr_q;
            end
            ST_RD_DATA: dma_out_valid = sto_rd_valid && in_range;
            ST_WR_DATA: begin
                dma_in_ready = in_range;
                sto_wr_valid = wr_fire;
                if (!in_range)
                    sto_wr_data = (before_off || same_q) ? buf_rd[0] : buf_rd[1];
            end
            ST_FINISH: begin
                done     = 1'b1;
                done_err = err_q;
            end
            default: ;
        endcase
    end

    // ---------------- transfer counters ----------------
    sad_xfer_count #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (xfer_load),
        .size  (xfer_size),
        .upd   ((state_q == ST_FINISH) && !err_q),
        .amount(len_q),
        .remain(xfer_remain),
        .index (xfer_index)
    );

    // ---------------- assertions ----------------
    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sto_cmd_valid |-> (busy && !done));  // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));  // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dma_out_valid && !dma_in_ready && !sto_wr_valid && !sto_cmd_valid));  // R2

    AST_READ_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_out_valid |-> !sto_wr_valid);  // R3

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && sto_err) |=> (done && done_err));  // R11
endmodule

// File: tb/sim_sector_align_dma.sv
`timescale 1ns/1ps
module sim_sector_align_dma;
    localparam int OFF_W = 32;
    localparam int LEN_W = 16;
    localparam int CNT_W = 24;
    localparam int SEC_W = OFF_W - 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [OFF_W-1:0] req_offset = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             busy, done, done_err;
    logic             xfer_load = 1'b0;
    logic [CNT_W-1:0] xfer_size = '0;
    logic [CNT_W-1:0] xfer_remain, xfer_index;
    logic             dma_in_valid = 1'b0;
    logic [7:0]       dma_in_data = '0;
    logic             dma_in_ready, dma_out_valid;
    logic [7:0]       dma_out_data;
    logic             sto_cmd_valid, sto_cmd_write;
    logic [SEC_W-1:0] sto_cmd_sector;
    logic             sto_rd_valid = 1'b0;
    logic [7:0]       sto_rd_data = '0;
    logic             sto_wr_valid;
    logic [7:0]       sto_wr_data;
    logic             sto_err = 1'b0;

    sector_align_dma #(.OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .SECT_LOG2(9)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_offset(req_offset), .req_len(req_len),
        .busy(busy), .done(done), .done_err(done_err),
        .xfer_load(xfer_load), .xfer_size(xfer_size), .xfer_remain(xfer_remain), .xfer_index(xfer_index),
        .dma_in_valid(dma_in_valid), .dma_in_data(dma_in_data), .dma_in_ready(dma_in_ready),
        .dma_out_valid(dma_out_valid), .dma_out_data(dma_out_data),
        .sto_cmd_valid(sto_cmd_valid), .sto_cmd_write(sto_cmd_write), .sto_cmd_sector(sto_cmd_sector),
        .sto_rd_valid(sto_rd_valid), .sto_rd_data(sto_rd_data),
        .sto_wr_valid(sto_wr_valid), .sto_wr_data(sto_wr_data), .sto_err(sto_err)
    );

    int checks = 0, fails = 0;
    logic [7:0] mem [4096];
    logic [7:0] refm [4096];
    logic [7:0] cap [8192];
    int cap_n = 0, sp = 0, cyc = 0, ncmd = 0;
    int cmd_sec [256];
    bit cmd_wr [256];
    bit rd_active = 0, err_arm = 0, err_pend = 0, last_err = 0;
    int rd_sec = 0, rd_ptr = 0, wr_sec = 0, wr_ptr = 0;
    int exp_rem = 0, exp_idx = 0;

    function automatic logic [7:0] gen(input int k);
        return 8'((k * 29 + 5) & 255);
    endfunction

    // storage and DMA models: drive at the falling edge, then sample what the
    // design will act on at the next rising edge
    always @(negedge clk) begin
        sto_rd_valid = 1'b0;
        sto_err = 1'b0;
        if (err_pend) begin
            sto_err = 1'b1;
            err_pend = 0;
            rd_active = 0;
        end else if (rd_active) begin
            sto_rd_valid = 1'b1;
            sto_rd_data = mem[rd_sec * 512 + rd_ptr];
            rd_ptr++;
            if (rd_ptr == 512) rd_active = 0;
        end
        dma_in_valid = ((cyc % 5) != 3);
        dma_in_data = gen(sp);
        #1;
        if (sto_cmd_valid) begin
            if (ncmd < 256) begin
                cmd_sec[ncmd] = int'(sto_cmd_sector);
                cmd_wr[ncmd] = sto_cmd_write;
            end
            ncmd++;
            if (sto_cmd_write) begin
                wr_sec = int'(sto_cmd_sector) & 7;
                wr_ptr = 0;
            end else begin
                rd_sec = int'(sto_cmd_sector) & 7;
                rd_ptr = 0;
                rd_active = 1;
                if (err_arm) begin
                    err_pend = 1;
                    err_arm = 0;
                end
            end
        end
        if (sto_wr_valid) begin
            mem[wr_sec * 512 + wr_ptr] = sto_wr_data;
            wr_ptr++;
        end
        if (dma_out_valid) begin
            cap[cap_n] = dma_out_data;
            cap_n++;
        end
        if (dma_in_valid && dma_in_ready) sp++;
        cyc++;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input int off, input int len, input bit wr);
        @(negedge clk);
        req_valid = 1'b1;
        req_offset = OFF_W'(off);
        req_len = LEN_W'(len);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        last_err = done_err;
        @(negedge clk);
        if (!last_err) begin
            exp_rem = (len > exp_rem) ? 0 : exp_rem - len;
            exp_idx += len;
        end
    endtask

    task automatic t_read(input int off, input int len);
        int c0 = cap_n, k0 = ncmd, bad = 0, nwr = 0;
        issue(off, len, 1'b0);
        for (int i = 0; i < len; i++)
            if (cap[c0 + i] !== refm[off + i]) bad++;
        for (int i = k0; i < ncmd; i++) if (cmd_wr[i]) nwr++;
        check(cap_n - c0 == len, "R3 read byte count", cap_n - c0, len);
        check(bad == 0, "R3 read byte values", bad, 0);
        check(nwr == 0, "R3 no write command on read", nwr, 0);
        check(ncmd - k0 == ((off + len - 1) >> 9) - (off >> 9) + 1, "R4 read command count",
              ncmd - k0, ((off + len - 1) >> 9) - (off >> 9) + 1);
        check(cmd_sec[k0] == (off >> 9) && cmd_sec[ncmd - 1] == ((off + len - 1) >> 9),
              "R4 first/last sector", cmd_sec[k0], off >> 9);
        check(last_err == 0, "R3 no error", last_err, 0);
    endtask

    task automatic t_write(input int off, input int len, input int exp_rb, input string tag);
        int s0 = sp, k0 = ncmd, nrd = 0, nwr = 0, order_bad = 0, bad = 0, first_w = -1;
        issue(off, len, 1'b1);
        for (int i = 0; i < len; i++) refm[off + i] = gen(s0 + i);
        for (int i = k0; i < ncmd; i++) begin
            if (cmd_wr[i]) begin
                nwr++;
                if (first_w < 0) first_w = cmd_sec[i];
            end else begin
                nrd++;
                if (nwr > 0) order_bad++;
            end
        end
        for (int a = 0; a < 4096; a++) if (mem[a] !== refm[a]) bad++;
        check(bad == 0, {tag, " storage contents after write"}, bad, 0);
        check(nrd == exp_rb, {tag, " read-back count"}, nrd, exp_rb);
        check(order_bad == 0, "R9 read-backs precede writes", order_bad, 0);
        check(nwr == ((off + len - 1) >> 9) - (off >> 9) + 1 && first_w == (off >> 9),
              "R4 write command span", nwr, ((off + len - 1) >> 9) - (off >> 9) + 1);
        check(sp - s0 == len, {tag, " DMA bytes consumed"}, sp - s0, len);
    endtask

    task automatic check_counters(input string tag);
        check(int'(xfer_remain) == exp_rem, {tag, " remain"}, xfer_remain, exp_rem);
        check(int'(xfer_index) == exp_idx, {tag, " index"}, xfer_index, exp_idx);
    endtask

    task automatic t_reset();
        check(!busy && !done && !done_err && !sto_cmd_valid && !sto_wr_valid &&
              !dma_out_valid && !dma_in_ready, "R1 reset outputs", busy, 0);
        check(xfer_remain == '0 && xfer_index == '0, "R1 reset counters", xfer_remain, 0);
    endtask

    task automatic t_load();
        @(negedge clk);
        xfer_load = 1'b1;
        xfer_size = CNT_W'(20000);
        @(negedge clk);
        xfer_load = 1'b0;
        exp_rem = 20000;
        exp_idx = 0;
        check_counters("R10 load");
    endtask

    task automatic t_zero();
        int k0 = ncmd;
        issue(100, 0, 1'b1);
        check(ncmd == k0, "R12 zero length issues no command", ncmd - k0, 0);
        check(last_err == 0 && !busy, "R12 zero length completes", busy, 0);
    endtask

    task automatic t_error();
        int k0 = ncmd, r0 = exp_rem, i0 = exp_idx;
        err_arm = 1;
        issue(0, 1024, 1'b0);
        check(last_err == 1, "R11 done_err on storage error", last_err, 1);
        repeat (10) @(negedge clk);
        check(ncmd - k0 == 1, "R11 no command after error", ncmd - k0, 1);
        check(int'(xfer_remain) == r0 && int'(xfer_index) == i0, "R11 counters unchanged",
              xfer_remain, r0);
    endtask

    task automatic t_busy_ignore();
        int c0 = cap_n, k0 = ncmd, nwr = 0, bad = 0;
        fork
            issue(0, 2048, 1'b0);
            begin
                repeat (40) @(negedge clk);
                req_valid = 1'b1;
                req_write = 1'b1;
                req_offset = OFF_W'(3000);
                req_len = LEN_W'(77);
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        for (int i = k0; i < ncmd; i++) if (cmd_wr[i]) nwr++;
        for (int i = 0; i < 2048; i++) if (cap[c0 + i] !== refm[i]) bad++;
        check(ncmd - k0 == 4 && nwr == 0, "R2 request while busy ignored", ncmd - k0, 4);
        check(bad == 0 && cap_n - c0 == 2048, "R2 data unaffected", bad, 0);
        repeat (5) @(negedge clk);
        check(!busy, "R13 busy cleared after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4096; a++) begin
            mem[a] = 8'((a * 7 + (a >> 8)) & 255);
            refm[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_load();
        t_read(512, 1024);
        t_read(700, 300);
        t_read(1000, 1100);
        check_counters("R10 after reads");
        t_write(1024, 512, 0, "R8 aligned");
        t_write(1636, 924, 1, "R5 head");
        t_write(2560, 600, 1, "R6 tail");
        t_write(300, 1000, 2, "R5 R6 both edges");
        t_write(3200, 50, 1, "R7 same sector");
        t_read(250, 3000);
        check_counters("R10 after writes");
        t_zero();
        t_error();
        t_busy_ignore();
        check_counters("R10 final");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule